// File: doc/BRIEF.md
# Multifunction Integer ALU

This block is the purely combinational execution unit of a small 32-bit integer datapath. It takes two operands and a 4-bit operation code and produces a result word, a zero flag and a signed-overflow flag in the same cycle. Inside it sit an adder/subtractor, a four-function bitwise unit and a signed less-than comparator. A result-select field steers one of these units, or a shift result that comes in from a separate shifter, onto the result bus.

The operation code is laid out as `{unit_sel[1:0], sub_op[1:0]}`. The upper two bits pick the unit. The lower two bits pick the function inside that unit. The zero flag lets a branch unit test two registers for equality through a subtraction. The comparator obtains its answer from the same adder, so the block carries only one carry chain.

Top module: `alu_core`

## Requirements
- R1: When op_code[3:2] is 00, result equals shift_in bit for bit.
- R2: When op_code[3:2] is 10 and op_code[0] is 0, result is opnd_a + opnd_b modulo 2^32.
- R3: When op_code[3:2] is 10 and op_code[0] is 1, result is opnd_a - opnd_b modulo 2^32. The subtraction is formed as opnd_a + ~opnd_b + 1.
- R4: When op_code[3:2] is 11, result is a bitwise function chosen by op_code[1:0]: 00 AND, 01 OR, 10 NOR, 11 XOR.
- R5: When op_code[3:2] is 01, result[0] is 1 exactly when opnd_a is less than opnd_b as signed two's-complement numbers, and result[31:1] is 0.
- R6: zero is 1 exactly when all 32 bits of result are 0.
- R7: ovf is the signed overflow of the internal adder. The adder subtracts when op_code[3:2] is 01, or when op_code[3:2] is 10 with op_code[0] = 1; otherwise it adds. Overflow is 1 when both adder inputs (after any inversion of opnd_b) share a sign and the sum's sign differs from it.
- R8: When op_code[3:2] is 10, op_code[1] has no effect on result, zero or ovf.
- R9: The R5 comparison stays correct when the difference overflows, for example 0x80000000 against 1 and 0x7FFFFFFF against 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| op_code | input | 4 | {unit select, sub-operation} |
| shift_in | input | 32 | Result from the external shifter |
| result | output | 32 | Selected result word |
| zero | output | 1 | Result is all zeros |
| ovf | output | 1 | Signed overflow of the adder |

## Verification
Every output is combinational. The result, the zero flag and the overflow flag therefore settle in the same cycle as the operand and code change that causes them, with no register on the path. The bench applies each stimulus on a rising clock edge and samples on the following falling edge, half a period later, so all three outputs have settled by the time they are read. No latency counting is needed.

// File: rtl/alu_pkg.sv
package alu_pkg;

   localparam int unsigned ALU_W = 32;

   typedef enum logic [1:0] {
      SEL_SHIFT = 2'b00,
      SEL_SLT   = 2'b01,
      SEL_ARITH = 2'b10,
      SEL_LOGIC = 2'b11
   } unit_sel_e;

   typedef enum logic [1:0] {
      BIT_AND = 2'b00,
      BIT_OR  = 2'b01,
      BIT_NOR = 2'b10,
      BIT_XOR = 2'b11
   } bit_fn_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int unsigned W          = 32,
   parameter bit          RIPPLE_ADD = 1'b0
) (
   input  logic [W-1:0] in_a,
   input  logic [W-1:0] in_b,
   input  logic         do_sub,
   output logic [W-1:0] sum,
   output logic         sovf
);

   logic [W-1:0] b_eff;

   always_comb b_eff = do_sub ? ~in_b : in_b;

   generate
      if (W < 2) begin : g_bad_width
         $error("alu_addsub needs at least two bits");
      end

      if (RIPPLE_ADD) begin : g_ripple
         logic [W:0] cy;
         assign cy[0] = do_sub;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]  = in_a[i] ^ b_eff[i] ^ cy[i];
            assign cy[i+1] = (in_a[i] & b_eff[i]) | (cy[i] & (in_a[i] ^ b_eff[i]));
         end
         assign sovf = cy[W] ^ cy[W-1];
      end else begin : g_behav
         assign sum  = in_a + b_eff + {{(W-1){1'b0}}, do_sub};
         assign sovf = (in_a[W-1] == b_eff[W-1]) && (sum[W-1] != in_a[W-1]);
      end
   endgenerate

   always_comb begin
      // R7
      ovf_sign_chk: assert (!sovf || (sum[W-1] != in_a[W-1]));
      // R3
      sub_self_chk: assert (!(do_sub && in_a == in_b) || sum == '0);
   end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
   import alu_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] in_a,
   input  logic [W-1:0] in_b,
   input  bit_fn_e      fn,
   output logic [W-1:0] res
);

   always_comb begin
      unique case (fn)
         BIT_AND: res = in_a & in_b;
         BIT_OR:  res = in_a | in_b;
         BIT_NOR: res = ~(in_a | in_b);
         BIT_XOR: res = in_a ^ in_b;
         default: res = '0;
      endcase
   end

   always_comb begin
      // R4
      nor_disjoint_chk: assert (fn != BIT_NOR || (res & (in_a | in_b)) == '0);
   end

endmodule

// File: rtl/alu_less.sv
module alu_less #(
   parameter int unsigned W = 32
) (
   input  logic         diff_sign,
   input  logic         diff_ovf,
   output logic [W-1:0] res
);

   logic lt;

   always_comb lt  = diff_sign ^ diff_ovf;
   always_comb res = {{(W-1){1'b0}}, lt};

   always_comb begin
      // R5
      slt_upper_zero_chk: assert (res[W-1:1] == '0);
   end

endmodule

// File: rtl/alu_core.sv
module alu_core
   import alu_pkg::*;
#(
   parameter int unsigned W          = ALU_W,
   parameter bit          RIPPLE_ADD = 1'b0
) (
   input  logic [W-1:0] opnd_a,
   input  logic [W-1:0] opnd_b,
   input  logic [3:0]   op_code,
   input  logic [W-1:0] shift_in,
   output logic [W-1:0] result,
   output logic         zero,
   output logic         ovf
);

   unit_sel_e    usel;
   logic         sub_en;
   logic [W-1:0] add_res;
   logic [W-1:0] bit_res;
   logic [W-1:0] lt_res;
   logic         add_ovf;

   always_comb usel   = unit_sel_e'(op_code[3:2]);
   always_comb sub_en = (usel == SEL_SLT) || ((usel == SEL_ARITH) && op_code[0]);

   alu_addsub #(.W(W), .RIPPLE_ADD(RIPPLE_ADD)) u_add (
      .in_a   (opnd_a),
      .in_b   (opnd_b),
      .do_sub (sub_en),
      .sum    (add_res),
      .sovf   (add_ovf)
   );

   alu_bitwise #(.W(W)) u_bit (
      .in_a (opnd_a),
      .in_b (opnd_b),
      .fn   (bit_fn_e'(op_code[1:0])),
      .res  (bit_res)
   );

   alu_less #(.W(W)) u_lt (
      .diff_sign (add_res[W-1]),
      .diff_ovf  (add_ovf),
      .res       (lt_res)
   );

   always_comb begin
      unique case (usel)
         SEL_SHIFT: result = shift_in;
         SEL_SLT:   result = lt_res;
         SEL_ARITH: result = add_res;
         SEL_LOGIC: result = bit_res;
         default:   result = '0;
      endcase
   end

   always_comb zero = (result == '0);
   always_comb ovf  = add_ovf;

   always_comb begin
      // R1
      shift_pass_chk: assert (usel != SEL_SHIFT || result == shift_in);
      // R6
      eq_zero_chk: assert (!(usel == SEL_ARITH && op_code[0] && opnd_a == opnd_b) || zero);
      // R9
      slt_equal_chk: assert (!(usel == SEL_SLT && opnd_a == opnd_b) || zero);
   end

endmodule

// File: tb/alu_core_test.sv
module alu_core_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic [31:0] a, b, sh;
   logic [3:0]  code;
   logic [31:0] result;
   logic        zero, ovf;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu_core uut (
      .opnd_a   (a),
      .opnd_b   (b),
      .op_code  (code),
      .shift_in (sh),
      .result   (result),
      .zero     (zero),
      .ovf      (ovf)
   );

   function automatic void model(input logic [31:0] x, input logic [31:0] y,
                                 input logic [3:0] c, input logic [31:0] s,
                                 output logic [31:0] r, output logic v);
      logic        sb;
      logic [31:0] yb, sum;
      sb  = (c[3:2] == 2'b01) || (c[3:2] == 2'b10 && c[0]);
      yb  = sb ? ~y : y;
      sum = x + yb + {31'd0, sb};
      v   = (x[31] == yb[31]) && (sum[31] != x[31]);
      case (c[3:2])
         2'b00: r = s;
         2'b01: r = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
         2'b10: r = c[0] ? x - y : x + y;
         default: case (c[1:0])
            2'b00: r = x & y;
            2'b01: r = x | y;
            2'b10: r = ~(x | y);
            default: r = x ^ y;
         endcase
      endcase
   endfunction

   function automatic string req_of(input logic [3:0] c);
      case (c[3:2])
         2'b00: return "R1";
         2'b01: return "R5/R9";
         2'b10: return c[0] ? "R3/R8" : "R2/R8";
         default: return "R4";
      endcase
   endfunction

   task automatic apply(input logic [31:0] x, input logic [31:0] y,
                        input logic [3:0] c, input logic [31:0] s);
      logic [31:0] er;
      logic        ev;
      @(posedge clk);
      a = x; b = y; code = c; sh = s;
      @(negedge clk);
      model(x, y, c, s, er, ev);
      n_chk++;
      if (result !== er) begin
         n_bad++;
         $display("FAIL %s result code=%h a=%h b=%h got %h exp %h", req_of(c), c, x, y, result, er);
      end
      n_chk++;
      if (zero !== (er == 32'd0)) begin
         n_bad++;
         $display("FAIL R6 zero code=%h a=%h b=%h got %b exp %b", c, x, y, zero, er == 32'd0);
      end
      n_chk++;
      if (ovf !== ev) begin
         n_bad++;
         $display("FAIL R7 ovf code=%h a=%h b=%h got %b exp %b", c, x, y, ovf, ev);
      end
   endtask

   initial begin
      logic [31:0] corner [6];
      void'($urandom(32'd1234));
      corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
      corner[2] = 32'h7FFF_FFFF; corner[3] = 32'h8000_0000;
      corner[4] = 32'hFFFF_FFFF; corner[5] = 32'h5A5A_A5A5;
      a = '0; b = '0; code = '0; sh = '0;
      // R1: first sample, shift path with all inputs zero
      apply(32'd0, 32'd0, 4'b0000, 32'd0);
      // R9: overflowing comparisons
      apply(32'h8000_0000, 32'h0000_0001, 4'b0100, 32'd0);
      apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0100, 32'd0);
      // R7: add overflow and R3 equal operands
      apply(32'h7FFF_FFFF, 32'h0000_0001, 4'b1000, 32'd0);
      apply(32'h1234_5678, 32'h1234_5678, 4'b1001, 32'd0);
      // R8: op_code[1] set for arithmetic
      apply(32'h8000_0000, 32'h0000_0001, 4'b1011, 32'd0);
      apply(32'h7FFF_FFFF, 32'h7FFF_FFFF, 4'b1010, 32'd0);
      for (int i = 0; i < 6; i++)
         for (int j = 0; j < 6; j++)
            for (int c = 0; c < 16; c++)
               apply(corner[i], corner[j], 4'(c), corner[(i + j) % 6]);
      for (int k = 0; k < 3000; k++) begin
         logic [31:0] x;
         x = $urandom;
         apply(x, (k % 7 == 0) ? x : $urandom, 4'($urandom), $urandom);
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

endmodule